// File: doc/BRIEF.md
# Microwire Serial Master Controller

This block is a register-mapped serial master for three-wire peripherals such as display drivers and converters. Software sees five 16-bit registers: a data register, a control/status word, two chip-select setup registers and a clock setup register. One control write picks one of four chip-select lines and either asserts or releases that line. A different control write starts a transfer on the line it names. The transfer shifts out a programmed number of bits from the data register and then shifts in a programmed number of bits from the slave.

Each chip-select line has its own setup: active level, the SCLK edge on which output bits change, the SCLK edge on which input bits are sampled, and a rate divider. A module clock enable and a predivider in the clock setup register set the base rate. Software polls a busy flag until the command finishes. A ready flag tells software that received bits are waiting in the data register.

Top module: `mw_master`

## Requirements
- R1: After reset all registers read 0, `sclk` and `sdo` are 0, and every chip-select pin is at its inactive level. With a setup level bit of 0 the line is active low, so `cs_o` = 4'hF.
- R2: The registers sit at these offsets: 0 data, 1 control/status, 2 setup A, 3 setup B, 4 clock setup. Setup registers read back bits 11:0 with the upper bits zero. Clock setup reads back bits 2:0. Control reads back as {ready, busy, 0, written bits 12:0}.
- R3: A control write with bit 13 = 0 is a chip-select command. After the next module tick it sets line bits 11:10 to asserted when bit 12 = 1 and to released when bit 12 = 0. Busy (bit 14) reads 1 until that tick.
- R4: A control write that arrives while busy is 1 is ignored entirely: no new transfer, no chip-select change, and no change to the stored control fields.
- R5: A control write with bit 13 = 1 shifts out the write count (bits 9:5) of bits, MSB first, starting from data bit 15. The data register shifts left by one for each bit.
- R6: After the write bits, the read count (bits 4:0) of bits is shifted into data bit 0. When a transfer with read count > 0 ends, ready (bit 15) becomes 1. A start clears ready, and a read of the data register clears it.
- R7: Setup bit 1 selects when output bits change. With 1, the bit is on `sdo` for the whole slot, before the rising SCLK edge. With 0, `sdo` changes on the rising SCLK edge.
- R8: Setup bit 0 selects when input bits are sampled: 0 on the rising SCLK edge, 1 on the falling SCLK edge.
- R9: Setup bit 2 is the active level of the line: 1 = active high, 0 = active low.
- R10: Clock setup bit 0 enables the module tick. Bits 2:1 (codes 0 to 3) give one tick every 2, 4, 7 or 10 clocks. Setup bits 4:3 (codes 0, 1, 2) give an SCLK period of 2, 4 or 8 ticks. SCLK idles low and each bit takes one SCLK period, low half first. While the tick is disabled, nothing progresses.
- R11: Lines 0 and 1 take their 6-bit setup field from setup A, and lines 2 and 3 from setup B. Odd lines use bits 11:6 and even lines use bits 5:0.
- R12: A start with both counts zero completes at once. Busy stays 0, SCLK does not toggle and the data register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used for ready clearing) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to slave |
| sdi | input | 1 | Serial data from slave |
| cs_o | output | 4 | Chip-select pins at their programmed levels |

## Verification
The properties take two things for granted. First, software never writes the data register while a transfer is in flight. Second, `sdi` only changes between clock edges. The bench drives every bus access and every `sdi` change on the falling clock edge, and it only writes data while the block is idle. A cycle model of the tick, SCLK and chip-select timing runs beside the block, and the bench checks the shifted bit streams against patterns that differ between the low and the high half of each slot.

// File: rtl/mw_master.sv
module mw_master (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sclk,
  output logic        sdo,
  input  logic        sdi,
  output logic [3:0]  cs_o
);
  logic [15:0] data_q;
  logic [12:0] ctl_q;
  logic [11:0] su_a, su_b;
  logic [2:0]  clk_q;
  logic [3:0]  pcnt, plim;
  logic        tick, rdy, cs_pend, xfer, samp;
  logic [3:0]  cs_on;
  logic [5:0]  cfg, left, wleft, nsum;
  logic [1:0]  hc, hlim;
  logic        busy, wr_ctl, accept, start, fin, rbit;

  function automatic logic [5:0] field(input logic [1:0] i, input logic [11:0] a, input logic [11:0] b);
    logic [11:0] r;
    r = i[1] ? b : a;
    return i[0] ? r[11:6] : r[5:0];
  endfunction

  always_comb
    case (clk_q[2:1])
      2'd0: plim = 4'd1;
      2'd1: plim = 4'd3;
      2'd2: plim = 4'd6;
      default: plim = 4'd9;
    endcase

  assign hlim   = (cfg[4:3] == 2'd0) ? 2'd0 : (cfg[4:3] == 2'd1) ? 2'd1 : 2'd3;
  assign tick   = clk_q[0] && (pcnt == plim);
  assign busy   = xfer | cs_pend;
  assign wr_ctl = bus_wr && (bus_addr == 3'd1);
  assign accept = wr_ctl && !busy;
  assign start  = accept && bus_wdata[13];
  assign nsum   = {1'b0, bus_wdata[9:5]} + {1'b0, bus_wdata[4:0]};
  assign fin    = xfer && tick && (hc == hlim) && sclk && (left == 6'd1);
  assign rbit   = cfg[0] ? sdi : samp;

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_cs
      logic [5:0] f;
      assign f = field(g[1:0], su_a, su_b);
      assign cs_o[g] = cs_on[g] ? f[2] : ~f[2];
    end
  endgenerate

  always_comb
    case (bus_addr)
      3'd0: bus_rdata = data_q;
      3'd1: bus_rdata = {rdy, busy, 1'b0, ctl_q};
      3'd2: bus_rdata = {4'd0, su_a};
      3'd3: bus_rdata = {4'd0, su_b};
      3'd4: bus_rdata = {13'd0, clk_q};
      default: bus_rdata = 16'd0;
    endcase

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0; ctl_q <= '0; su_a <= '0; su_b <= '0; clk_q <= '0;
      pcnt <= '0; rdy <= 1'b0; cs_pend <= 1'b0; cs_on <= '0; xfer <= 1'b0;
      samp <= 1'b0; cfg <= '0; left <= '0; wleft <= '0; hc <= '0;
      sclk <= 1'b0; sdo <= 1'b0;
    end else begin
      pcnt <= (!clk_q[0] || tick) ? 4'd0 : pcnt + 4'd1;
      if (bus_wr)
        case (bus_addr)
          3'd0: if (!xfer) data_q <= bus_wdata;
          3'd2: su_a <= bus_wdata[11:0];
          3'd3: su_b <= bus_wdata[11:0];
          3'd4: clk_q <= bus_wdata[2:0];
          default: ;
        endcase
      if (accept) ctl_q <= bus_wdata[12:0];

      if (accept && !bus_wdata[13]) cs_pend <= 1'b1;
      else if (cs_pend && tick) begin
        cs_pend <= 1'b0;
        cs_on[ctl_q[11:10]] <= ctl_q[12];
      end

      if (start) rdy <= 1'b0;
      else if (fin && wleft == 6'd0) rdy <= 1'b1;
      else if (bus_rd && bus_addr == 3'd0) rdy <= 1'b0;

      if (start && nsum != 6'd0) begin
        xfer  <= 1'b1;
        cfg   <= field(bus_wdata[11:10], su_a, su_b);
        left  <= nsum;
        wleft <= {1'b0, bus_wdata[9:5]};
        hc    <= '0;
        sclk  <= 1'b0;
        sdo   <= field(bus_wdata[11:10], su_a, su_b) >> 1 & 6'd1 ? (bus_wdata[9:5] != 5'd0) & data_q[15] : 1'b0;
      end else if (xfer && tick) begin
        if (hc != hlim) hc <= hc + 2'd1;
        else begin
          hc <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            if (!cfg[1] && wleft != 6'd0) sdo <= data_q[15];
            if (!cfg[0]) samp <= sdi;
          end else begin
            sclk   <= 1'b0;
            data_q <= {data_q[14:0], (wleft == 6'd0) ? rbit : 1'b0};
            if (wleft != 6'd0) wleft <= wleft - 6'd1;
            left   <= left - 6'd1;
            sdo    <= (wleft > 6'd1) ? (cfg[1] ? data_q[14] : sdo) : 1'b0;
            if (left == 6'd1) xfer <= 1'b0;
          end
        end
      end
    end
  end
endmodule

module mw_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       sdo,
  input logic       xfer,
  input logic       tick,
  input logic       en,
  input logic       rdy,
  input logic       wr_ctl,
  input logic [3:0] cs_on
);
  // R12
  idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !xfer |-> !sclk);
  // R5
  idle_sdo_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !xfer |-> !sdo);
  // R6
  ready_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(rdy) |-> $fell(xfer));
  // R3
  cs_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(cs_on));
  // R10
  halt_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |=> $stable(sclk));
  // R4
  no_cs_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n) xfer && wr_ctl |=> $stable(cs_on));
endmodule

bind mw_master mw_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdo(sdo), .xfer(xfer), .tick(tick),
  .en(clk_q[0]), .rdy(rdy), .wr_ctl(wr_ctl), .cs_on(cs_on)
);

// File: tb/sim_mw_master.sv
module sim_mw_master;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, sdi = 0;
  logic [2:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic sclk, sdo;
  logic [3:0] cs_o;

  mw_master u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .sdo(sdo), .sdi(sdi), .cs_o(cs_o));

  always #2 clk = ~clk;

  int tests = 0, fails = 0, mism = 0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // shadow state and cycle model
  logic [11:0] sh_a = 0, sh_b = 0;
  bit m_en = 0, m_busy = 0, m_pend = 0, m_sclk = 0, m_cmd = 0, acc, tk;
  int m_pre = 2, m_pc = 0, m_hc = 0, m_half = 1, m_left = 0, m_idx = 0, nsum;
  bit [3:0] m_cs = 0;

  function automatic logic [5:0] fld(int i);
    logic [11:0] r;
    r = (i >= 2) ? sh_b : sh_a;
    return (i % 2 == 1) ? r[11:6] : r[5:0];
  endfunction
  function automatic int pre_of(logic [1:0] c);
    return (c == 0) ? 2 : (c == 1) ? 4 : (c == 2) ? 7 : 10;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_busy = 0; m_pend = 0; m_sclk = 0; m_hc = 0; m_cs = 0; m_en = 0; m_pre = 2;
      sh_a = 0; sh_b = 0;
    end else begin
      acc = bus_wr && bus_addr == 1 && !m_busy && !m_pend;
      tk = m_en && (m_pc == m_pre - 1);
      m_pc = (!m_en || tk) ? 0 : m_pc + 1;
      if (m_pend && tk) begin m_cs[m_idx] = m_cmd; m_pend = 0; end
      if (m_busy && tk) begin
        if (m_hc == m_half / 2 - 1 || m_half == 1) begin
          m_hc = 0;
          if (!m_sclk) m_sclk = 1;
          else begin m_sclk = 0; m_left--; if (m_left == 0) m_busy = 0; end
        end else m_hc++;
      end
      if (bus_wr) begin
        if (bus_addr == 4) begin m_en = bus_wdata[0]; m_pre = pre_of(bus_wdata[2:1]); end
        if (bus_addr == 2) sh_a = bus_wdata[11:0];
        if (bus_addr == 3) sh_b = bus_wdata[11:0];
      end
      if (acc) begin
        if (bus_wdata[13]) begin
          nsum = bus_wdata[9:5] + bus_wdata[4:0];
          if (nsum > 0) begin
            m_busy = 1; m_left = nsum; m_hc = 0; m_sclk = 0;
            // half period in ticks = period/2; stored as period
            m_half = (fld(bus_wdata[11:10]) >> 3 == 0) ? 2 : ((fld(bus_wdata[11:10]) >> 3) == 1) ? 4 : 8;
          end
        end else begin m_pend = 1; m_idx = bus_wdata[11:10]; m_cmd = bus_wdata[12]; end
      end
    end
  end

  // observation of the serial pins
  bit prev_s = 0, prev_o = 0;
  int rc = 0, nrise = 0, hi_cnt = 0, last_hi = 0;
  logic [63:0] pa = 0, pb = 0;
  bit wq[$], pq[$];

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk !== m_sclk) mism++;
      for (int i = 0; i < 4; i++)
        if (cs_o[i] !== (m_cs[i] ? fld(i) >> 2 & 6'd1 : ~(fld(i) >> 2) & 6'd1)) mism++;
    end
    if (sclk && !prev_s) begin rc++; nrise++; wq.push_back(sdo); pq.push_back(prev_o); hi_cnt = 0; end
    if (sclk) hi_cnt++;
    if (!sclk && prev_s) last_hi = hi_cnt;
    sdi = sclk ? pb[(rc - 1) & 63] : pa[rc & 63];
    prev_s = sclk; prev_o = sdo;
  end

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask
  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 3000; i++) begin rd(1, v); if (!v[14]) return; end
    chk("R3 busy timeout", 1, 0);
  endtask
  task automatic clrq();
    wq.delete(); pq.delete(); rc = 0;
  endtask

  initial begin
    #(4 * 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v, d;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    for (int a = 0; a < 5; a++) begin rd(a[2:0], v); chk("R1 reg", v, 0); end
    chk("R1 sclk", sclk, 0); chk("R1 sdo", sdo, 0); chk("R1 cs", cs_o, 4'hF);
    // R2
    wr(2, 16'hFABC); rd(2, v); chk("R2 setupA", v, 16'h0ABC);
    wr(4, 16'hFFF7); rd(4, v); chk("R2 clk", v, 16'h0007);
    // setup: line0 drive-fall, line1 active high div4, line2 sample-fall div8, line3 active high
    wr(4, 16'h0001); wr(2, 16'h0302); wr(3, 16'h0111);
    rd(2, v); chk("R2 setupA", v, 16'h0302);
    chk("R11 levels", cs_o, 4'b0101);
    // R10 / R3: command held while tick disabled
    wr(4, 16'h0000); wr(1, 16'h1000);
    repeat (10) @(negedge clk);
    rd(1, v); chk("R3 busy held", v[14], 1); chk("R10 halted cs", cs_o[0], 1);
    wr(4, 16'h0001); wait_idle();
    chk("R3 assert", cs_o[0], 0); chk("R9 active low", cs_o, 4'b0100);
    rd(1, v); chk("R2 ctrl", v, 16'h1000);
    wr(1, 16'h1C00); wait_idle(); chk("R9 active high", cs_o[3], 1);
    // R5 / R7 / R4
    d = 16'hB380; wr(0, d); clrq();
    wr(1, 16'h2120);
    wr(1, 16'h3C05); wr(1, 16'h1400);
    wait_idle();
    chk("R4 rises", wq.size(), 9);
    for (int i = 0; i < 9; i++) chk("R5 bit", wq[i], d[15 - i]);
    chk("R7 fall early", pq[0], d[15]);
    rd(1, v); chk("R4 ctrl kept", v, 16'h0120); chk("R4 cs kept", cs_o[1], 0);
    rd(0, v); chk("R5 data", v, 16'(d << 9));
    // R6 / R8 rising sample on line1
    pa = 64'h2D0; pb = ~pa; wr(0, 16'hF000); clrq();
    wr(1, 16'h2486); wait_idle();
    for (int i = 0; i < 4; i++) chk("R5 bit", wq[i], 1);
    chk("R7 rise late", pq[0], 0);
    chk("R10 high len", last_hi, 4);
    rd(1, v); chk("R6 ready", v[15], 1);
    rd(0, v); chk("R8 rising data", v, 16'h002D);
    rd(1, v); chk("R6 cleared", v[15], 0);
    // R8 falling sample on line2
    wr(0, 16'h1234); clrq();
    wr(1, 16'h2805); wait_idle();
    rd(1, v); chk("R6 ready", v[15], 1);
    // R12
    n0 = nrise;
    wr(1, 16'h2000); rd(1, v);
    chk("R12 not busy", v[14], 0); chk("R12 ready cleared", v[15], 0);
    repeat (20) @(negedge clk); chk("R12 no sclk", nrise, n0);
    rd(0, v); chk("R8 falling data", v, 16'h469E);
    // R10 predivider 10, divider 2
    wr(4, 16'h0007); wr(0, 16'h8000); clrq();
    wr(1, 16'h2020); wait_idle();
    chk("R10 high len", last_hi, 10); chk("R5 bit", wq[0], 1);
    // R3 release
    wr(1, 16'h0000); wait_idle(); chk("R3 release", cs_o[0], 1);
    chk("R10 cycle model", mism, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule